// File: doc/BRIEF.md
# DMA Request Remap Crossbar

This block routes peripheral DMA request lines onto the channels of a DMA controller. Software picks one peripheral for each channel by writing a 6-bit selector into a lane of a 32-bit remap word. Each word carries four channel lanes. The crossbar then forwards the chosen peripheral's request to that channel. It also returns the channel's acknowledge to the same peripheral. Requests and acknowledges each pass through one register stage.

A selector is written into storage on every write. The routing itself changes only when the same write also sets the word's top bit. This lets software stage new selectors and then switch all four lanes of a word in a single cycle. A selector at or above the number of peripherals leaves its channel unrouted. This includes the all-ones code, which is the value after reset.

Top module: `dma_req_xbar`

## Requirements
- R1: After reset every selector reads back as 0x3F, every `ch_req` bit is 0 and every `periph_ack` bit is 0.
- R2: Channel c's selector sits in the word at address BASE_ADDR + 4*(c/4), bits (c mod 4)*8 +: 6. A read returns the stored selectors with lane bits 7:6 and word bit 31 as 0. The data appears on `reg_rdata` in the cycle after the read strobe.
- R3: A write with bit 31 clear updates the stored selectors of that word but leaves the active routing unchanged.
- R4: A write with bit 31 set commits all four lane values of that word to the active routing. The new routing applies to requests sampled at the next clock edge.
- R5: For a routed channel, `ch_req[c]` equals `periph_req[sel]` delayed by one clock.
- R6: A channel whose active selector is 43 to 63 keeps `ch_req` low and passes no acknowledge.
- R7: `periph_ack[p]` is the OR of `ch_ack` over all channels actively routed to p, delayed by one clock.
- R8: Several channels may select the same peripheral, and each of them then follows its request.
- R9: Writes to addresses other than the remap words change neither the stored selectors nor the routing, and reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (12) | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |
| periph_req | input | NUM_PERIPH (43) | Peripheral request lines |
| periph_ack | output | NUM_PERIPH (43) | Acknowledge returned to the peripherals |
| ch_req | output | NUM_CH (8) | Request lines to the DMA channels |
| ch_ack | input | NUM_CH (8) | Acknowledge from the DMA channels |

## Verification
A wrong stored selector shows on `reg_rdata` one cycle after the next read of its word. A wrong committed selector shows on `ch_req` exactly one clock after a request pattern that separates the intended peripheral from the wrong one. The same fault shows on `periph_ack` one clock after a matching acknowledge. The bench walks a single request bit across every peripheral and applies all 256 acknowledge patterns after each remap, so a misrouted channel cannot stay hidden. A commit that fires when it should not, or fails to fire, is caught one clock later by the request check that follows the staged write.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;
  localparam int LANE_W         = 8;
  localparam int LANES_PER_WORD = 4;
  localparam int WORD_W         = 32;
  localparam int COMMIT_BIT     = 31;
  localparam int WORD_BYTES     = 4;
endpackage

// File: rtl/xbar_regs.sv
`timescale 1ns/1ps
module xbar_regs
  import xbar_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int SEL_W     = 6,
  parameter int ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h154
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [WORD_W-1:0]       wdata,
  output logic [WORD_W-1:0]       rdata,
  output logic [NUM_CH*SEL_W-1:0] act_flat
);
  localparam int NUM_WORDS = (NUM_CH + LANES_PER_WORD - 1) / LANES_PER_WORD;

  logic [SEL_W-1:0] stored_q [NUM_CH];
  logic [SEL_W-1:0] active_q [NUM_CH];
  logic [NUM_WORDS-1:0] hit;
  logic [WORD_W-1:0] rd_word;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
    assign hit[w] = (addr == ADDR_W'(BASE_ADDR + ADDR_W'(w * WORD_BYTES)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) begin
        stored_q[c] <= '1;
        active_q[c] <= '1;
      end
    end else if (wr) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (hit[c / LANES_PER_WORD]) begin
          stored_q[c] <= wdata[(c % LANES_PER_WORD) * LANE_W +: SEL_W];
          if (wdata[COMMIT_BIT])
            active_q[c] <= wdata[(c % LANES_PER_WORD) * LANE_W +: SEL_W];
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit[c / LANES_PER_WORD])
        rd_word[(c % LANES_PER_WORD) * LANE_W +: SEL_W] = stored_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_word;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flat
    assign act_flat[c*SEL_W +: SEL_W] = active_q[c];
  end
endmodule

// File: rtl/xbar_req_mux.sv
`timescale 1ns/1ps
module xbar_req_mux #(
  parameter int NUM_CH     = 8,
  parameter int NUM_PERIPH = 43,
  parameter int SEL_W      = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_PERIPH-1:0]   periph_req,
  input  logic [NUM_CH*SEL_W-1:0] act_flat,
  output logic [NUM_CH-1:0]       ch_req
);
  localparam int PAD_W = 1 << SEL_W;

  logic [PAD_W-1:0] req_pad;
  assign req_pad = PAD_W'(periph_req);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SEL_W-1:0] sel;
    logic             in_range;
    assign sel      = act_flat[c*SEL_W +: SEL_W];
    assign in_range = (32'(sel) < NUM_PERIPH);
    always_ff @(posedge clk) begin
      if (rst) ch_req[c] <= 1'b0;
      else     ch_req[c] <= in_range & req_pad[sel];
    end
  end
endmodule

// File: rtl/xbar_ack_merge.sv
`timescale 1ns/1ps
module xbar_ack_merge #(
  parameter int NUM_CH     = 8,
  parameter int NUM_PERIPH = 43,
  parameter int SEL_W      = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       ch_ack,
  input  logic [NUM_CH*SEL_W-1:0] act_flat,
  output logic [NUM_PERIPH-1:0]   periph_ack
);
  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_per
    logic any;
    always_comb begin
      any = 1'b0;
      for (int c = 0; c < NUM_CH; c++)
        any = any | ((act_flat[c*SEL_W +: SEL_W] == SEL_W'(p)) & ch_ack[c]);
    end
    always_ff @(posedge clk) begin
      if (rst) periph_ack[p] <= 1'b0;
      else     periph_ack[p] <= any;
    end
  end
endmodule

// File: rtl/dma_req_xbar.sv
`timescale 1ns/1ps
module dma_req_xbar #(
  parameter int NUM_CH     = 8,
  parameter int NUM_PERIPH = 43,
  parameter int SEL_W      = 6,
  parameter int ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h154
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [NUM_PERIPH-1:0] periph_req,
  output logic [NUM_PERIPH-1:0] periph_ack,
  output logic [NUM_CH-1:0]     ch_req,
  input  logic [NUM_CH-1:0]     ch_ack
);
  logic [NUM_CH*SEL_W-1:0] act_flat;

  xbar_regs #(
    .NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .act_flat(act_flat)
  );

  xbar_req_mux #(
    .NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W)
  ) u_req (
    .clk(clk), .rst(rst), .periph_req(periph_req), .act_flat(act_flat),
    .ch_req(ch_req)
  );

  xbar_ack_merge #(
    .NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W)
  ) u_ack (
    .clk(clk), .rst(rst), .ch_ack(ch_ack), .act_flat(act_flat),
    .periph_ack(periph_ack)
  );
endmodule

// File: rtl/xbar_checker.sv
`timescale 1ns/1ps
module xbar_checker #(
  parameter int NUM_CH     = 8,
  parameter int NUM_PERIPH = 43,
  parameter int SEL_W      = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    reg_wr,
  input logic                    reg_rd,
  input logic [31:0]             reg_wdata,
  input logic [31:0]             reg_rdata,
  input logic [NUM_PERIPH-1:0]   periph_req,
  input logic [NUM_PERIPH-1:0]   periph_ack,
  input logic [NUM_CH-1:0]       ch_req,
  input logic [NUM_CH-1:0]       ch_ack,
  input logic [NUM_CH*SEL_W-1:0] act_flat
);
  logic [NUM_CH-1:0] unrouted;
  always_comb begin
    for (int c = 0; c < NUM_CH; c++)
      unrouted[c] = (32'(act_flat[c*SEL_W +: SEL_W]) >= NUM_PERIPH);
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (ch_req == '0 && periph_ack == '0));

  p_commit_bit_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> (reg_rdata[31] == 1'b0));

  p_staged_write_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_wdata[31]) |=> $stable(act_flat));

  p_quiet_requests_r5: assert property (@(posedge clk) disable iff (rst)
    (periph_req == '0) |=> (ch_req == '0));

  p_unrouted_low_r6: assert property (@(posedge clk) disable iff (rst)
    (unrouted == {NUM_CH{1'b1}}) |=> (ch_req == '0));

  p_quiet_acks_r7: assert property (@(posedge clk) disable iff (rst)
    (ch_ack == '0) |=> (periph_ack == '0));
endmodule

bind dma_req_xbar xbar_checker #(
  .NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
  .periph_ack(periph_ack), .ch_req(ch_req), .ch_ack(ch_ack),
  .act_flat(act_flat)
);

// File: tb/dma_req_xbar_bench.sv
`timescale 1ns/1ps
module dma_req_xbar_bench;
  localparam int NCH = 8;
  localparam int NP  = 43;
  localparam logic [11:0] BASE = 12'h154;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] periph_req = '0;
  logic [NP-1:0] periph_ack;
  logic [NCH-1:0] ch_req;
  logic [NCH-1:0] ch_ack = '0;

  int n_chk = 0, n_fail = 0;
  logic [5:0] msel [NCH];
  logic [63:0] lcg = 64'h1234_5678_9abc_def1;

  always #2 clk = ~clk;

  dma_req_xbar u_dma_req_xbar (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .periph_req(periph_req), .periph_ack(periph_ack),
    .ch_req(ch_req), .ch_ack(ch_ack)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  function automatic logic [NCH-1:0] exp_req(input logic [NP-1:0] pr);
    logic [NCH-1:0] r = '0;
    for (int c = 0; c < NCH; c++)
      if (msel[c] < NP) r[c] = pr[msel[c]];
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_ack(input logic [NCH-1:0] ca);
    logic [NP-1:0] r = '0;
    for (int c = 0; c < NCH; c++)
      if (msel[c] < NP && ca[c]) r[msel[c]] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] r = '0;
    for (int l = 0; l < 4; l++) r[l*8 +: 6] = msel[w*4 + l];
    return r;
  endfunction

  task automatic req_chk(input logic [NP-1:0] pr, input string tag);
    periph_req = pr;
    @(negedge clk);
    chk(ch_req == exp_req(pr), tag, 64'(ch_req), 64'(exp_req(pr)));
  endtask

  task automatic ack_chk(input logic [NCH-1:0] ca, input string tag);
    ch_ack = ca;
    @(negedge clk);
    chk(periph_ack == exp_ack(ca), tag, 64'(periph_ack), 64'(exp_ack(ca)));
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) msel[c] = 6'h3F;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ch_req == '0, "R1 ch_req", 64'(ch_req), 0);
    chk(periph_ack == '0, "R1 periph_ack", 64'(periph_ack), 0);
    rd_chk(BASE, 32'h3F3F3F3F, "R1 word0");
    rd_chk(BASE + 4, 32'h3F3F3F3F, "R1 word1");

    // R3 staged write: storage changes, routing does not
    wr(BASE, 32'h04030201);
    rd_chk(BASE, 32'h04030201, "R3 staged readback");
    req_chk('1, "R3 staged routing held");
    ack_chk('1, "R3 staged ack held");
    ch_ack = '0;

    // R4 commit with the same write, then walk each request (R5)
    wr(BASE, 32'h84030201);
    msel[0] = 1; msel[1] = 2; msel[2] = 3; msel[3] = 4;
    rd_chk(BASE, 32'h04030201, "R2 commit bit reads 0");
    for (int p = 0; p < NP; p++) req_chk(NP'(1) << p, "R4 commit walk");

    // Sweep of selector layouts, including unrouted codes (R6) and masked lane bits (R2)
    for (int r = 0; r < 16; r++) begin
      for (int w = 0; w < 2; w++) begin
        logic [31:0] d;
        for (int l = 0; l < 4; l++) begin
          msel[w*4+l] = 6'((r*7 + (w*4+l)*11 + 3) % 64);
          d[l*8 +: 8] = {2'b11, msel[w*4+l]};
        end
        d[31] = 1'b1;
        wr(BASE + 12'(w*4), d);
      end
      rd_chk(BASE, exp_word(0), "R2 lane layout word0");
      rd_chk(BASE + 4, exp_word(1), "R2 lane layout word1");
      for (int p = 0; p < NP; p++) req_chk(NP'(1) << p, "R5 R6 walking request");
      for (int k = 0; k < 6; k++) begin
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        req_chk(lcg[63:21], "R5 R6 mixed request");
      end
      req_chk('1, "R6 all requests");
      for (int a = 0; a < 256; a++) ack_chk(8'(a), "R7 ack merge");
      ch_ack = '0;
    end

    // R8 broadcast: every channel on peripheral 5
    wr(BASE, 32'h85050505);
    wr(BASE + 4, 32'h85050505);
    for (int c = 0; c < NCH; c++) msel[c] = 6'd5;
    req_chk(NP'(1) << 5, "R8 broadcast on");
    chk(ch_req == 8'hFF, "R8 all channels", 64'(ch_req), 64'hFF);
    req_chk(NP'(1) << 6, "R8 broadcast off");
    ack_chk(8'h81, "R8 shared ack");

    // R9 foreign addresses ignored
    wr(BASE + 8, 32'h80000000);
    wr(BASE - 4, 32'h80000000);
    wr(12'h000, 32'h81010101);
    rd_chk(BASE, exp_word(0), "R9 word0 unchanged");
    rd_chk(BASE + 4, exp_word(1), "R9 word1 unchanged");
    rd_chk(BASE + 8, 32'h0, "R9 foreign read");
    req_chk(NP'(1) << 5, "R9 routing unchanged");
    periph_req = '0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule